// File: doc/BRIEF.md
# Cascadable Register-ALU Slice

This block is one narrow slice of a microprogrammed datapath. It holds a small two-port scratchpad, an eight-function ALU with carry-in, an extension register (here called the Q register) and two one-bit shifters. Several slices sit side by side to form a wider word. Their shift end pins are wired to their neighbours, their carry outputs go to an external lookahead unit, and their result pins share one bus.

In each cycle the microcode picks two scratchpad locations through the A and B addresses. It also picks the left operand R (scratchpad A, external data or zero) and the right operand S (scratchpad B, Q, scratchpad A or zero), an ALU function, and the destination actions. The result can be written back to the B location unshifted or shifted by one place. The Q register can load the result or shift by one place. A RAM shift paired with a Q shift gives a double-width shift across the pair. The end pins that feed the vacated bit positions are wired outside the slice. Wiring them to a constant gives a plain shift, and wiring them to the opposite end's output gives a rotate.

Reads are combinational and writes take effect on the rising clock edge. A register can therefore be read, modified and written back in a single cycle.

Top module: `rsalu_slice`

## Requirements
- R1: A synchronous active-high reset clears all scratchpad entries and the Q register to zero.
- R2: Function codes 0, 1 and 2 are arithmetic. Code 0 gives R+S+cin, code 1 gives S-R-1+cin and code 2 gives R-S-1+cin. The result is taken modulo 2^W, and `cout` is the carry out of the top bit of that sum (inverted operands included).
- R3: Function codes 3 to 7 give R|S, R&S, ~R&S, R^S and ~(R^S) respectively.
- R4: For function codes 3 to 7, `cout` and `ovf` are 0.
- R5: Both scratchpad ports read combinationally at their addresses. When `ram_op` is not 0, the shifted result is written to the B address at the rising edge, and a later read of that address returns it.
- R6: `q_op` controls the Q register. Code 0 holds it, 1 loads the ALU result, 2 shifts it toward the MSB with `q_lsb_in` entering bit 0, and 3 shifts it toward the LSB with `q_msb_in` entering the MSB.
- R7: `ram_op` 1 writes the result unchanged. Code 2 writes it shifted toward the MSB with `ram_lsb_in` as the new bit 0, and code 3 writes it shifted toward the LSB with `ram_msb_in` as the new MSB. `ram_msb_out`/`ram_lsb_out` always show the result's MSB/LSB, and `q_msb_out`/`q_lsb_out` always show the current Q register's MSB/LSB.
- R8: When `oe` is 1, `y` carries the ALU result if `out_sel` is 0 and scratchpad port A if `out_sel` is 1. When `oe` is 0, `y` is high impedance and another driver can own the bus.
- R9: Let the active operands be X and Y: ~R for code 1, ~S for code 2, and R and S otherwise. `prop_n` is low exactly when X|Y is all ones. `gen_n` is low exactly when X+Y (no carry-in) carries out of the top bit.
- R10: `zero` is high when the result is all zeros and `sign` equals the result MSB. For arithmetic codes, `ovf` is high when X and Y have equal MSBs and the result MSB differs from them.
- R11: `r_sel` picks R: 0 for scratchpad A, 1 for `d_in`, 2 or 3 for zero. `s_sel` picks S: 0 for scratchpad B, 1 for Q, 2 for scratchpad A, 3 for zero. Selecting A for both operands with function 0 doubles a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | 4 | Scratchpad port A address |
| b_addr | input | 4 | Scratchpad port B address, also the write address |
| d_in | input | 4 | External data operand |
| r_sel | input | 2 | R operand source select |
| s_sel | input | 2 | S operand source select |
| fn | input | 3 | ALU function code |
| cin | input | 1 | Carry in |
| ram_op | input | 2 | Scratchpad write/shift action |
| q_op | input | 2 | Q register action |
| out_sel | input | 1 | Output source: 0 result, 1 scratchpad A |
| oe | input | 1 | Output enable, active high |
| ram_lsb_in | input | 1 | Bit entering the LSB on a RAM shift toward MSB |
| ram_msb_in | input | 1 | Bit entering the MSB on a RAM shift toward LSB |
| q_lsb_in | input | 1 | Bit entering the Q LSB on a Q shift toward MSB |
| q_msb_in | input | 1 | Bit entering the Q MSB on a Q shift toward LSB |
| y | output | 4 | Tristate result bus |
| ram_lsb_out | output | 1 | ALU result LSB |
| ram_msb_out | output | 1 | ALU result MSB |
| q_lsb_out | output | 1 | Q register LSB |
| q_msb_out | output | 1 | Q register MSB |
| cout | output | 1 | Carry out |
| gen_n | output | 1 | Carry generate, active low |
| prop_n | output | 1 | Carry propagate, active low |
| zero | output | 1 | Result is zero |
| sign | output | 1 | Result MSB |
| ovf | output | 1 | Signed overflow |

## Verification
The bench builds the slice with its default width of 4 and 16 scratchpad entries. At that size every operand value, every function code and every register address can be reached within a short run. Directed passes sweep the whole register file after reset and after loading. They cover doubling through the A-to-both-operands path, a chained RAM-plus-Q double-width shift and a rotate wired through the end pins. A long pseudo-random stretch then mixes all source, destination and tristate codes against the behavioural model.

// File: rtl/rsalu_pkg.sv
package rsalu_pkg;
    localparam int SLICE_W    = 4;
    localparam int SLICE_REGS = 16;

    typedef enum logic [2:0] {
        FN_ADD   = 3'd0,
        FN_SUBR  = 3'd1,
        FN_SUBS  = 3'd2,
        FN_OR    = 3'd3,
        FN_AND   = 3'd4,
        FN_NOTRS = 3'd5,
        FN_EXOR  = 3'd6,
        FN_EXNOR = 3'd7
    } alu_fn_e;

    typedef enum logic [1:0] {
        RSRC_A  = 2'd0,
        RSRC_D  = 2'd1,
        RSRC_Z0 = 2'd2,
        RSRC_Z1 = 2'd3
    } r_src_e;

    typedef enum logic [1:0] {
        SSRC_B = 2'd0,
        SSRC_Q = 2'd1,
        SSRC_A = 2'd2,
        SSRC_Z = 2'd3
    } s_src_e;

    // Shared by the scratchpad and Q destinations; for Q, SH_PASS means load.
    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_PASS  = 2'd1,
        SH_LEFT  = 2'd2,
        SH_RIGHT = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic cout;
        logic gen_n;
        logic prop_n;
        logic ovf;
    } alu_stat_t;

    function automatic logic fn_is_arith(alu_fn_e f);
        return (f == FN_ADD) || (f == FN_SUBR) || (f == FN_SUBS);
    endfunction
endpackage

// File: rtl/rsalu_regfile.sv
module rsalu_regfile
    import rsalu_pkg::*;
#(
    parameter int W     = SLICE_W,
    parameter int DEPTH = SLICE_REGS,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    input  logic          we,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[rd_b_addr] <= wr_data;
        end
    end

    assign rd_a = mem[rd_a_addr];
    assign rd_b = mem[rd_b_addr];

    // R5: a write lands at the B address by the next cycle
    assert_ram_write_R5: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(rd_b_addr)] == $past(wr_data));
endmodule

// File: rtl/rsalu_operand_mux.sv
module rsalu_operand_mux
    import rsalu_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  r_src_e       r_sel,
    input  s_src_e       s_sel,
    input  logic [W-1:0] a_dat,
    input  logic [W-1:0] b_dat,
    input  logic [W-1:0] q_dat,
    input  logic [W-1:0] d_dat,
    output logic [W-1:0] r_op,
    output logic [W-1:0] s_op
);
    always_comb begin
        unique case (r_sel)
            RSRC_A:  r_op = a_dat;
            RSRC_D:  r_op = d_dat;
            default: r_op = '0;
        endcase
    end

    always_comb begin
        unique case (s_sel)
            SSRC_B:  s_op = b_dat;
            SSRC_Q:  s_op = q_dat;
            SSRC_A:  s_op = a_dat;
            default: s_op = '0;
        endcase
    end
endmodule

// File: rtl/rsalu_alu.sv
module rsalu_alu
    import rsalu_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] r_op,
    input  logic [W-1:0] s_op,
    input  logic         cin,
    output logic [W-1:0] f,
    output alu_stat_t    stat
);
    logic [W-1:0] x, y;
    logic [W:0]   sum;
    logic         arith;
    logic         g_acc, p_acc;

    always_comb begin
        arith = fn_is_arith(fn);
        x = r_op;
        y = s_op;
        if (fn == FN_SUBR) x = ~r_op;
        if (fn == FN_SUBS) y = ~s_op;
        sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    end

    always_comb begin
        unique case (fn)
            FN_OR:    f = r_op | s_op;
            FN_AND:   f = r_op & s_op;
            FN_NOTRS: f = ~r_op & s_op;
            FN_EXOR:  f = r_op ^ s_op;
            FN_EXNOR: f = ~(r_op ^ s_op);
            default:  f = sum[W-1:0];
        endcase
    end

    // Ripple form of the group terms; one level per bit.
    always_comb begin
        g_acc = 1'b0;
        p_acc = 1'b1;
        for (int i = 0; i < W; i++) begin
            g_acc = (x[i] & y[i]) | ((x[i] | y[i]) & g_acc);
            p_acc = p_acc & (x[i] | y[i]);
        end
    end

    always_comb begin
        stat.gen_n  = ~g_acc;
        stat.prop_n = ~p_acc;
        stat.cout   = arith & sum[W];
        stat.ovf    = arith & (x[W-1] == y[W-1]) & (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/rsalu_shifter.sv
module rsalu_shifter
    import rsalu_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] din,
    input  shift_op_e    op,
    input  logic         lsb_in,
    input  logic         msb_in,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (op)
            SH_LEFT:  dout = {din[W-2:0], lsb_in};
            SH_RIGHT: dout = {msb_in, din[W-1:1]};
            default:  dout = din;
        endcase
    end
endmodule

// File: rtl/rsalu_slice.sv
module rsalu_slice
    import rsalu_pkg::*;
#(
    parameter int W    = SLICE_W,
    parameter int REGS = SLICE_REGS,
    localparam int AW  = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  logic [W-1:0]  d_in,
    input  logic [1:0]    r_sel,
    input  logic [1:0]    s_sel,
    input  logic [2:0]    fn,
    input  logic          cin,
    input  logic [1:0]    ram_op,
    input  logic [1:0]    q_op,
    input  logic          out_sel,
    input  logic          oe,
    input  logic          ram_lsb_in,
    input  logic          ram_msb_in,
    input  logic          q_lsb_in,
    input  logic          q_msb_in,
    output wire  [W-1:0]  y,
    output logic          ram_lsb_out,
    output logic          ram_msb_out,
    output logic          q_lsb_out,
    output logic          q_msb_out,
    output logic          cout,
    output logic          gen_n,
    output logic          prop_n,
    output logic          zero,
    output logic          sign,
    output logic          ovf
);
    alu_fn_e   fn_e;
    shift_op_e ram_op_e, q_op_e;
    logic [W-1:0] a_dat, b_dat, q_reg, r_op, s_op, f, ram_wdata, q_shifted;
    alu_stat_t stat;

    assign fn_e     = alu_fn_e'(fn);
    assign ram_op_e = shift_op_e'(ram_op);
    assign q_op_e   = shift_op_e'(q_op);

    rsalu_regfile #(.W(W), .DEPTH(REGS)) u_regs (
        .clk(clk), .rst(rst), .rd_a_addr(a_addr), .rd_b_addr(b_addr),
        .we(ram_op_e != SH_NONE), .wr_data(ram_wdata), .rd_a(a_dat), .rd_b(b_dat)
    );

    rsalu_operand_mux #(.W(W)) u_opmux (
        .r_sel(r_src_e'(r_sel)), .s_sel(s_src_e'(s_sel)),
        .a_dat(a_dat), .b_dat(b_dat), .q_dat(q_reg), .d_dat(d_in),
        .r_op(r_op), .s_op(s_op)
    );

    rsalu_alu #(.W(W)) u_alu (
        .fn(fn_e), .r_op(r_op), .s_op(s_op), .cin(cin), .f(f), .stat(stat)
    );

    rsalu_shifter #(.W(W)) u_ram_sh (
        .din(f), .op(ram_op_e), .lsb_in(ram_lsb_in), .msb_in(ram_msb_in), .dout(ram_wdata)
    );

    rsalu_shifter #(.W(W)) u_q_sh (
        .din(q_reg), .op(q_op_e), .lsb_in(q_lsb_in), .msb_in(q_msb_in), .dout(q_shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg <= '0;
        end else begin
            unique case (q_op_e)
                SH_PASS:          q_reg <= f;
                SH_LEFT, SH_RIGHT: q_reg <= q_shifted;
                default:          q_reg <= q_reg;
            endcase
        end
    end

    assign y = oe ? (out_sel ? a_dat : f) : {W{1'bz}};

    assign ram_lsb_out = f[0];
    assign ram_msb_out = f[W-1];
    assign q_lsb_out   = q_reg[0];
    assign q_msb_out   = q_reg[W-1];
    assign cout        = stat.cout;
    assign gen_n       = stat.gen_n;
    assign prop_n      = stat.prop_n;
    assign ovf         = stat.ovf;
    assign zero        = (f == '0);
    assign sign        = f[W-1];

    // R2: plain addition matches the operand sum
    assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (fn_e == FN_ADD) |-> ({cout, f} == ({1'b0, r_op} + {1'b0, s_op} + {{W{1'b0}}, cin})));

    // R4: logic functions never report carry or overflow
    assert_logic_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !fn_is_arith(fn_e) |-> (!cout && !ovf));

    // R9: full propagate with carry in forces carry out
    assert_prop_carry_R9: assert property (@(posedge clk) disable iff (rst)
        (fn_is_arith(fn_e) && !prop_n && cin) |-> cout);

    // R9: an active generate forces carry out
    assert_gen_carry_R9: assert property (@(posedge clk) disable iff (rst)
        (fn_is_arith(fn_e) && !gen_n) |-> cout);

    // R10: addition overflow only with like-signed operands and a flipped result sign
    assert_add_ovf_R10: assert property (@(posedge clk) disable iff (rst)
        (fn_e == FN_ADD && ovf) |-> (r_op[W-1] == s_op[W-1] && sign != r_op[W-1]));

    // R6: a load places the result in Q
    assert_q_load_R6: assert property (@(posedge clk) disable iff (rst)
        (q_op_e == SH_PASS) |=> (q_reg == $past(f)));
endmodule

// File: tb/tb_rsalu_slice.sv
module tb_rsalu_slice;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic [3:0] a_addr, b_addr, d_in;
    logic [1:0] r_sel, s_sel, ram_op, q_op;
    logic [2:0] fn;
    logic       cin, out_sel, oe;
    logic       ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in;
    logic       tb_en;
    logic [3:0] tb_val;
    wire  [3:0] bus;
    wire        ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out;
    wire        cout, gen_n, prop_n, zero, sign, ovf;

    assign bus = tb_en ? tb_val : 4'bzzzz;

    rsalu_slice dut (
        .clk(clk), .rst(rst), .a_addr(a_addr), .b_addr(b_addr), .d_in(d_in),
        .r_sel(r_sel), .s_sel(s_sel), .fn(fn), .cin(cin), .ram_op(ram_op), .q_op(q_op),
        .out_sel(out_sel), .oe(oe), .ram_lsb_in(ram_lsb_in), .ram_msb_in(ram_msb_in),
        .q_lsb_in(q_lsb_in), .q_msb_in(q_msb_in), .y(bus),
        .ram_lsb_out(ram_lsb_out), .ram_msb_out(ram_msb_out),
        .q_lsb_out(q_lsb_out), .q_msb_out(q_msb_out), .cout(cout), .gen_n(gen_n),
        .prop_n(prop_n), .zero(zero), .sign(sign), .ovf(ovf)
    );

    int mem [16];
    int qm;
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_r();
        if (r_sel == 2'd0) return mem[a_addr];
        if (r_sel == 2'd1) return int'(d_in);
        return 0;
    endfunction

    function automatic int ref_s();
        case (s_sel)
            2'd0:    return mem[b_addr];
            2'd1:    return qm;
            2'd2:    return mem[a_addr];
            default: return 0;
        endcase
    endfunction

    // Inputs must be set just after a falling edge; checks land 1 ns later,
    // and the model advances on the following rising edge.
    task automatic cycle(string tag);
        int r, s, x, yy, fv, co, ov, ex_bus;
        bit arith;
        #1;
        r = ref_r();
        s = ref_s();
        arith = (fn < 3);
        x = r;
        yy = s;
        if (fn == 3'd1) x = 15 - r;
        if (fn == 3'd2) yy = 15 - s;
        co = 0;
        case (fn)
            3'd3: fv = r | s;
            3'd4: fv = r & s;
            3'd5: fv = (15 - r) & s;
            3'd6: fv = r ^ s;
            3'd7: fv = 15 - (r ^ s);
            default: begin
                fv = (x + yy + int'(cin)) % 16;
                co = (x + yy + int'(cin)) / 16;
            end
        endcase
        ov = (arith && ((x / 8) == (yy / 8)) && ((fv / 8) != (x / 8))) ? 1 : 0;
        ex_bus = oe ? (out_sel ? mem[a_addr] : fv) : int'(tb_val);
        chk(tag, int'(bus), ex_bus);
        chk(arith ? "R2 cout" : "R4 cout", int'(cout), co);
        chk(arith ? "R10 ovf" : "R4 ovf", int'(ovf), ov);
        chk("R9 prop_n", int'(prop_n), ((x | yy) == 15) ? 0 : 1);
        chk("R9 gen_n", int'(gen_n), ((x + yy) >= 16) ? 0 : 1);
        chk("R10 zero", int'(zero), (fv == 0) ? 1 : 0);
        chk("R10 sign", int'(sign), fv / 8);
        chk("R7 ram ends", int'({ram_msb_out, ram_lsb_out}), (fv / 8) * 2 + (fv % 2));
        chk("R7 q ends", int'({q_msb_out, q_lsb_out}), (qm / 8) * 2 + (qm % 2));
        @(posedge clk);
        if (!rst) begin
            case (ram_op)
                2'd1: mem[b_addr] = fv;
                2'd2: mem[b_addr] = ((fv * 2) % 16) + int'(ram_lsb_in);
                2'd3: mem[b_addr] = int'(ram_msb_in) * 8 + fv / 2;
                default: ;
            endcase
            case (q_op)
                2'd1: qm = fv;
                2'd2: qm = ((qm * 2) % 16) + int'(q_lsb_in);
                2'd3: qm = int'(q_msb_in) * 8 + qm / 2;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle();
        a_addr = 0; b_addr = 0; d_in = 0; r_sel = 2; s_sel = 3; fn = 0; cin = 0;
        ram_op = 0; q_op = 0; out_sel = 0; oe = 1; tb_en = 0; tb_val = 0;
        ram_lsb_in = 0; ram_msb_in = 0; q_lsb_in = 0; q_msb_in = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < 16; i++) mem[i] = 0;
        qm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: every register reads zero after reset, via port A output path
        for (int i = 0; i < 16; i++) begin
            idle(); a_addr = 4'(i); out_sel = 1;
            cycle("R1 reset reg");
        end
        idle(); s_sel = 1; fn = 3;  // R1: Q reads zero (0 | Q)
        cycle("R1 reset q");

        // R5 / R11: load each register from d_in, then read all back
        for (int i = 0; i < 16; i++) begin
            idle(); r_sel = 1; d_in = 4'((i * 7 + 3) % 16); b_addr = 4'(i); ram_op = 1;
            cycle("R11 d path");
        end
        for (int i = 0; i < 16; i++) begin
            idle(); a_addr = 4'(i); out_sel = 1;
            cycle("R5 readback");
        end

        // R11: doubling with A on both operands, read-modify-write in one cycle
        idle(); r_sel = 0; s_sel = 2; a_addr = 5; b_addr = 5; ram_op = 1;
        cycle("R11 double");
        idle(); a_addr = 5; out_sel = 1;
        cycle("R5 double readback");

        // R6: load Q, then a chained double-width shift toward LSB
        idle(); r_sel = 1; d_in = 4'hb; q_op = 1;
        cycle("R6 q load");
        for (int k = 0; k < 4; k++) begin
            idle(); s_sel = 0; b_addr = 9; ram_op = 3; q_op = 3;
            ram_msb_in = 0;
            q_msb_in = 1'(mem[9] % 2);
            cycle("R6 dbl shift");
        end
        idle(); s_sel = 1; fn = 3;
        cycle("R6 q after shift");
        for (int k = 0; k < 3; k++) begin
            idle(); q_op = 2; q_lsb_in = 1'(k % 2);
            cycle("R6 q left");
        end

        // R7: rotate a register toward MSB through the end pins
        for (int k = 0; k < 5; k++) begin
            idle(); s_sel = 0; b_addr = 2; ram_op = 2;
            ram_lsb_in = 1'(mem[2] / 8);
            cycle("R7 rotate");
        end
        idle(); a_addr = 2; out_sel = 1;
        cycle("R7 rotate readback");

        // R8: another driver owns the bus while the slice is disabled
        idle(); oe = 0; tb_en = 1; tb_val = 4'h6; r_sel = 1; d_in = 4'h9;
        cycle("R8 tristate");

        // R2/R3 corner: R-S-1+cin with equal operands gives zero and carry
        idle(); r_sel = 0; s_sel = 2; a_addr = 3; fn = 2; cin = 1;
        cycle("R2 subs equal");

        // Mixed pseudo-random traffic across all codes
        for (int n = 0; n < 3000; n++) begin
            a_addr = 4'($urandom); b_addr = 4'($urandom); d_in = 4'($urandom);
            r_sel = 2'($urandom); s_sel = 2'($urandom); fn = 3'($urandom);
            cin = 1'($urandom); ram_op = 2'($urandom); q_op = 2'($urandom);
            out_sel = 1'($urandom); oe = 1'($urandom % 4 != 0);
            tb_en = !oe; tb_val = 4'($urandom);
            ram_lsb_in = 1'($urandom); ram_msb_in = 1'($urandom);
            q_lsb_in = 1'($urandom); q_msb_in = 1'($urandom);
            cycle(fn < 3 ? "R2 random result" : "R3 random result");
        end

        finish_run();
    end
endmodule